// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block walks a small state machine through three armed states (S1, S2, S3) and a terminal Final step, in response to three per-cycle comparator match pulses. Each armed state owns a 4-bit selection code. The code says which match channels cause a move and where each of them leads. When the machine reaches Final, it emits a single-cycle trigger pulse and drops back to the disarmed condition.

Software, or a test harness, loads the three codes through a small write port while the sequencer is idle. It then pulses `arm` and lets the comparator matches drive the walk. A sticky flag vector records which channels have matched since the last arm, so it is clear afterwards which events took part in a capture. All outputs are registered. A change on the inputs in one cycle becomes visible just after the next rising edge.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset, `state` is 2'b00 (disarmed), `trigger` is 0, `flags` is 8'h00 and all three selection codes are 0.
- R2: The state encoding is 00 for disarmed, 01 for S1, 10 for S2 and 11 for S3. A pulse on `arm` while disarmed moves the machine to S1 and clears `flags`. A pulse on `arm` while armed is ignored. A pulse on `disarm` returns the machine to 00 without a trigger, and `disarm` wins over a simultaneous `arm`.
- R3: Each channel's destination is written here as A, B or F. Destination A means S2 from S1, S1 from S2, and S1 from S3. Destination B means S3 from S1, S3 from S2, and S2 from S3. F is Final.
- R4: Selection codes map channels to destinations as follows:
  - 1: M0 goes to A.
  - 2: M1 goes to B.
  - 3: M0 goes to F.
  - 4: M1 goes to F.
  - 5: M2 goes to B and M0 goes to F.
  - 6: M2 goes to B and M1 goes to F.
  - 7: M1 goes to A and M0 goes to F.
  - 8: M2 goes to A and M1 goes to F.
  - 9: M0 goes to B and M2 goes to F.
  - 10: M1 and M2 both go to A, and M0 goes to F.
  - 11: M0 goes to A, and M1 and M2 both go to F.
  - 12: M2 goes to F.
  - 13: M2 goes to A.
  - 14: M0 goes to A and M1 goes to B.
- R5: Codes 0 and 15 are reserved and cause no move. A match on a channel that the current code leaves unspecified has no effect on the state.
- R6: When several matches arrive in one cycle, any match leading to F wins. Otherwise the lowest-numbered channel with a destination wins.
- R7: A match that wins toward F drives `trigger` high for exactly one cycle, with `state` already at 00 in that cycle.
- R8: A write with `wr_en` sets the code of S1, S2 or S3 for `wr_sel` 01, 10 or 11 respectively, but only while disarmed. Writes made while armed are ignored.
- R9: While armed, `flags[n]` sets when `match[n]` is high and then stays set. Matches while disarmed leave `flags` unchanged. `flags[7:3]` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start a sequence (pulse) |
| disarm | input | 1 | Abort the sequence (pulse) |
| wr_en | input | 1 | Selection code write strobe |
| wr_sel | input | 2 | Target state of the write (01 S1, 10 S2, 11 S3) |
| wr_data | input | 4 | Selection code to write |
| match | input | 3 | Per-cycle comparator match pulses, bit n is channel n |
| state | output | 2 | Current sequencer state |
| trigger | output | 1 | One-cycle pulse on reaching Final |
| flags | output | 8 | Sticky match flags, bits 2..0 used |

## Verification
The assertions assume that `arm` and `disarm` are single-cycle pulses and that selection codes are loaded only while disarmed. They also assume that match pulses are synchronous to `clk` and never unknown after reset. The stimulus drives every input on the falling edge and returns the strobes to 0 after one cycle. Writes issued while armed are deliberate probes of the lock. The bench follows each such write with a match whose outcome differs between the old and the new code.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int NCH    = 3;
  localparam int CODE_W = 4;
  localparam int NST    = 3;

  typedef enum logic [1:0] {
    ST_OFF = 2'b00,
    ST_S1  = 2'b01,
    ST_S2  = 2'b10,
    ST_S3  = 2'b11
  } seq_state_t;

  typedef enum logic [1:0] {
    D_NONE = 2'b00,
    D_A    = 2'b01,
    D_B    = 2'b10,
    D_FIN  = 2'b11
  } dest_t;

  // Per-channel destinations for one selection code; channel n at [2n+1:2n].
  function automatic logic [2*NCH-1:0] code_map(input logic [CODE_W-1:0] code);
    logic [2*NCH-1:0] m;
    case (code)
      4'd1:    m = {D_NONE, D_NONE, D_A  };
      4'd2:    m = {D_NONE, D_B,    D_NONE};
      4'd3:    m = {D_NONE, D_NONE, D_FIN};
      4'd4:    m = {D_NONE, D_FIN,  D_NONE};
      4'd5:    m = {D_B,    D_NONE, D_FIN};
      4'd6:    m = {D_B,    D_FIN,  D_NONE};
      4'd7:    m = {D_NONE, D_A,    D_FIN};
      4'd8:    m = {D_A,    D_FIN,  D_NONE};
      4'd9:    m = {D_FIN,  D_NONE, D_B  };
      4'd10:   m = {D_A,    D_A,    D_FIN};
      4'd11:   m = {D_FIN,  D_FIN,  D_A  };
      4'd12:   m = {D_FIN,  D_NONE, D_NONE};
      4'd13:   m = {D_A,    D_NONE, D_NONE};
      4'd14:   m = {D_NONE, D_B,    D_A  };
      default: m = '0;
    endcase
    return m;
  endfunction

  // Resolve an abstract destination into a concrete state, given the current one.
  function automatic seq_state_t dest_state(input seq_state_t cur, input dest_t d);
    seq_state_t s;
    case (cur)
      ST_S1:   s = (d == D_A) ? ST_S2 : ST_S3;
      ST_S2:   s = (d == D_A) ? ST_S1 : ST_S3;
      ST_S3:   s = (d == D_A) ? ST_S1 : ST_S2;
      default: s = ST_OFF;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dbg_seq_cfg.sv
module dbg_seq_cfg
  import dbg_seq_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   armed,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [CW-1:0]          wr_data,
  output logic [NST-1:0][CW-1:0] code_q
);

  logic wr_ok;
  assign wr_ok = wr_en && !armed;

  for (genvar s = 0; s < NST; s++) begin : g_code
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q[s] <= '0;
      else if (wr_ok && (wr_sel == 2'(s + 1)))
        code_q[s] <= wr_data;
    end
  end

  // R8
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(code_q));

endmodule

// File: rtl/dbg_seq_pick.sv
module dbg_seq_pick
  import dbg_seq_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  seq_state_t     cur,
  input  logic [CW-1:0]  code,
  input  logic [NCH-1:0] match,
  output logic           go,
  output logic           go_fin,
  output seq_state_t     go_state
);

  logic [2*NCH-1:0] map;
  dest_t            hit [NCH];
  logic [NCH-1:0]   fin_vec;
  logic [NCH-1:0]   mov_vec;

  assign map = code_map(code);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit[c]     = match[c] ? dest_t'(map[2*c +: 2]) : D_NONE;
    assign fin_vec[c] = (hit[c] == D_FIN);
    assign mov_vec[c] = (hit[c] == D_A) || (hit[c] == D_B);
  end

  always_comb begin
    dest_t win;
    win = D_NONE;
    for (int c = NCH - 1; c >= 0; c--)
      if (mov_vec[c]) win = hit[c];
    go_fin   = (cur != ST_OFF) && (|fin_vec);
    go       = (cur != ST_OFF) && ((|fin_vec) || (|mov_vec));
    go_state = go_fin ? ST_OFF : dest_state(cur, win);
  end

  // R5
  pick_idle_chk: assert final (!((code == '0) || (&code)) || !go);

endmodule

// File: rtl/dbg_seq_core.sv
module dbg_seq_core
  import dbg_seq_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic           disarm,
  input  logic [NCH-1:0] match,
  input  logic           go,
  input  logic           go_fin,
  input  seq_state_t     go_state,
  output seq_state_t     state_q,
  output logic           trig_q,
  output logic [FW-1:0]  flags_q
);

  logic armed, arm_fire;
  assign armed    = (state_q != ST_OFF);
  assign arm_fire = arm && !disarm && !armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      if (disarm)
        state_q <= ST_OFF;
      else if (arm_fire)
        state_q <= ST_S1;
      else if (go) begin
        state_q <= go_state;
        trig_q  <= go_fin;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= '0;
    else if (arm_fire)
      flags_q <= '0;
    else if (armed)
      flags_q[NCH-1:0] <= flags_q[NCH-1:0] | match;
  end

  // R7
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q);
  // R7
  trig_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> (state_q == ST_OFF));
  // R2
  arm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && arm && !disarm) |=> (state_q == ST_S1) && (flags_q == '0));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !go && !disarm) |=> $stable(state_q));
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed || !arm) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              disarm,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [NCH-1:0]    match,
  output logic [1:0]        state,
  output logic              trigger,
  output logic [FLAG_W-1:0] flags
);

  seq_state_t                st, go_state;
  logic                      go, go_fin;
  logic [NST-1:0][CODE_W-1:0] code_q;
  logic [CODE_W-1:0]         cur_code;

  assign cur_code = (st == ST_OFF) ? '0 : code_q[st - 2'd1];

  dbg_seq_cfg #(.CW(CODE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .armed(st != ST_OFF),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .code_q(code_q)
  );

  dbg_seq_pick #(.CW(CODE_W)) u_pick (
    .cur(st), .code(cur_code), .match(match),
    .go(go), .go_fin(go_fin), .go_state(go_state)
  );

  dbg_seq_core #(.FW(FLAG_W)) u_core (
    .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .match(match),
    .go(go), .go_fin(go_fin), .go_state(go_state),
    .state_q(st), .trig_q(trigger), .flags_q(flags)
  );

  assign state = st;

  // R9
  flag_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FLAG_W-1:NCH] == '0);

endmodule

// File: tb/tb_dbg_seq_top.sv
module tb_dbg_seq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0, disarm = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'b00;
  logic [3:0] wr_data = 4'h0;
  logic [2:0] match = 3'b000;
  logic [1:0] state;
  logic       trigger;
  logic [7:0] flags;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dbg_seq_top dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .match(match),
    .state(state), .trigger(trigger), .flags(flags)
  );

  // {match[2:0], state[1:0], trigger, flags[2:0]}; codes S1=1, S2=2, S3=10
  localparam logic [8:0] VEC [10] = '{
    {3'b000, 2'b01, 1'b0, 3'b000},
    {3'b010, 2'b01, 1'b0, 3'b010},
    {3'b001, 2'b10, 1'b0, 3'b011},
    {3'b101, 2'b10, 1'b0, 3'b111},
    {3'b010, 2'b11, 1'b0, 3'b111},
    {3'b100, 2'b01, 1'b0, 3'b111},
    {3'b001, 2'b10, 1'b0, 3'b111},
    {3'b010, 2'b11, 1'b0, 3'b111},
    {3'b111, 2'b00, 1'b1, 3'b111},
    {3'b111, 2'b00, 1'b0, 3'b111}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic d, input logic w, input logic [1:0] s,
                     input logic [3:0] v, input logic [2:0] m);
    @(negedge clk);
    arm = a; disarm = d; wr_en = w; wr_sel = s; wr_data = v; match = m;
    @(posedge clk);
    #1;
    @(negedge clk);
    arm = 0; disarm = 0; wr_en = 0; match = 3'b000;
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] v);
    cyc(0, 0, 1, s, v, 3'b000);
  endtask

  task automatic m(input logic [2:0] v);
    cyc(0, 0, 0, 2'b00, 4'h0, v);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 state", {6'b0, state}, 8'h00);
    chk("R1 trigger", {7'b0, trigger}, 8'h00);
    chk("R1 flags", flags, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    // R1: codes reset to 0 (reserved) -> arming and matching moves nothing
    cyc(1, 0, 0, 2'b00, 4'h0, 3'b000);
    m(3'b111);
    chk("R1 code0 hold", {6'b0, state}, 8'h01);
    cyc(0, 1, 0, 2'b00, 4'h0, 3'b000);

    // Table walk (R4, R3, R6, R7, R9)
    wr(2'b01, 4'd1); wr(2'b10, 4'd2); wr(2'b11, 4'd10);
    cyc(1, 0, 0, 2'b00, 4'h0, 3'b000);
    chk("R2 arm state", {6'b0, state}, 8'h01);
    chk("R2 arm flags", flags, 8'h00);
    for (int i = 0; i < 10; i++) begin
      m(VEC[i][8:6]);
      chk($sformatf("R4 vec%0d state", i), {6'b0, state}, {6'b0, VEC[i][5:4]});
      chk($sformatf("R7 vec%0d trigger", i), {7'b0, trigger}, {7'b0, VEC[i][3]});
      chk($sformatf("R9 vec%0d flags", i), flags, {5'b0, VEC[i][2:0]});
    end

    // R2: re-arm clears flags; arm while armed ignored
    cyc(1, 0, 0, 2'b00, 4'h0, 3'b000);
    chk("R2 rearm flags", flags, 8'h00);
    m(3'b001);
    chk("R3 S1 A to S2", {6'b0, state}, 8'h02);
    cyc(1, 0, 0, 2'b00, 4'h0, 3'b000);
    chk("R2 arm while armed", {6'b0, state}, 8'h02);
    chk("R2 arm keeps flags", flags, 8'h01);

    // R8: write while armed ignored (code 4 would trigger on M1)
    wr(2'b10, 4'd4);
    m(3'b010);
    chk("R8 locked state", {6'b0, state}, 8'h03);
    chk("R8 locked trigger", {7'b0, trigger}, 8'h00);

    // R2: disarm, no trigger; disarm wins over arm
    cyc(1, 1, 0, 2'b00, 4'h0, 3'b000);
    chk("R2 disarm state", {6'b0, state}, 8'h00);
    chk("R2 disarm trigger", {7'b0, trigger}, 8'h00);

    // R6: lowest channel wins without Final (S3 code 14)
    wr(2'b11, 4'd14);
    cyc(1, 0, 0, 2'b00, 4'h0, 3'b000);
    m(3'b001); m(3'b010);
    chk("R3 S2 B to S3", {6'b0, state}, 8'h03);
    m(3'b011);
    chk("R6 lowest wins", {6'b0, state}, 8'h01);
    cyc(0, 1, 0, 2'b00, 4'h0, 3'b000);

    // R6/R7: Final beats lower channel (S1 code 2, S3 code 9)
    wr(2'b01, 4'd2); wr(2'b11, 4'd9);
    cyc(1, 0, 0, 2'b00, 4'h0, 3'b000);
    m(3'b010);
    chk("R3 S1 B to S3", {6'b0, state}, 8'h03);
    m(3'b101);
    chk("R6 final wins", {7'b0, trigger}, 8'h01);
    chk("R7 final state", {6'b0, state}, 8'h00);
    m(3'b000);
    chk("R7 one cycle", {7'b0, trigger}, 8'h00);

    // R5: reserved code 15 moves nothing
    wr(2'b01, 4'd15);
    cyc(1, 0, 0, 2'b00, 4'h0, 3'b000);
    m(3'b111);
    chk("R5 reserved state", {6'b0, state}, 8'h01);
    chk("R9 flags upper zero", flags, 8'h07);
    cyc(0, 1, 0, 2'b00, 4'h0, 3'b000);

    // R5: unspecified channel ignored (S1 code 13 uses M2 only)
    wr(2'b01, 4'd13);
    cyc(1, 0, 0, 2'b00, 4'h0, 3'b000);
    m(3'b011);
    chk("R5 unspecified", {6'b0, state}, 8'h01);
    m(3'b100);
    chk("R4 code13 M2 to A", {6'b0, state}, 8'h02);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule